// File: doc/BRIEF.md
# Dot-Matrix LCD Segment Driver Core

This block is the digital core of a segment-side LCD driver. Display data arrives serially on two inputs and is clocked into two 20-stage shift sections by a shared shift strobe. The strobe, and the load input, are treated as synchronous enables sampled by a faster system clock: a high-to-low transition of the strobe advances both sections by one stage. While the load input is high, a 40-bit output latch follows the shift sections. While it is low, the latch keeps its last contents.

Each of the 40 segment outputs carries a 2-bit code that names one of four bias rails. The code depends on the latched display bit and on a frame-alternation input. Serial taps after stage 20 and stage 40 let the two sections be joined into one chain, or let several drivers be cascaded. A build-time parameter can join the sections internally. In that mode the second section is fed from stage 20 and its own serial input has no effect.

Top module: `seg_driver_core`

## Requirements
- R1: In split mode (CHAIN_INT=0), a shift event loads `di1_in` into stage 1 and `di21_in` into stage 21. Stage k (2..20 and 22..40) takes the previous value of stage k-1. Segment output k (1..40) reflects stage k.
- R2: A shift event is a system-clock edge at which `cp_in` is sampled low and was sampled high at the edge before it. A strobe held low for several clocks shifts only once. Without a shift event, no stage changes.
- R3: `do20_out` presents stage 20. A bit entered on `di1_in` appears there after exactly 20 shift events.
- R4: `do40_out` presents stage 40.
- R5: On every system-clock edge where `load_in` is high, the latch takes the current shift-stage contents. The new value shows on the segment outputs after that edge.
- R6: While `load_in` is low, the segment latch does not change. Further shifting does not alter the segment outputs.
- R7: Output k sits at bits [2k-1:2k-2] of `seg_lvl_out`. Its code is set by the latched bit and `df_in` as follows: bit 1 with df 0 gives 00 (highest rail V1); bit 0 with df 0 gives 01 (V2); bit 0 with df 1 gives 10 (V3); bit 1 with df 1 gives 11 (lowest rail V4). The code follows a change of `df_in` with no clock delay.
- R8: A system-clock edge with `rst_n` low clears all 40 stages and the latch to zero.
- R9: With CHAIN_INT=1, stage 21 takes the previous value of stage 20 on each shift event. `di21_in` is ignored, and `do40_out` shows a bit entered on `di1_in` after 40 shift events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_in | input | 1 | Shift strobe; its falling transition advances both sections |
| load_in | input | 1 | Latch enable, level sensitive |
| df_in | input | 1 | Frame-alternation signal |
| di1_in | input | 1 | Serial data into stage 1 |
| di21_in | input | 1 | Serial data into stage 21 (split mode only) |
| do20_out | output | 1 | Serial tap at stage 20 |
| do40_out | output | 1 | Serial tap at stage 40 |
| seg_lvl_out | output | 80 | Two-bit rail code per segment, segment 1 in the low bits |

## Verification
A corrupt shift stage reaches a serial tap within at most 20 further shift events. It reaches the segment codes at the next clock with load high. A wrong edge decision, such as shifting on a held-low strobe or on a rising transition, moves a tap one stage off at once. A latch that fails to hold, or to follow, shows on `seg_lvl_out` one system clock after the load level is sampled. A wrong rail mapping shows with no delay whenever `df_in` toggles over a latched pattern that has both bit values.

// File: rtl/seg_pkg.sv
package seg_pkg;

  localparam int unsigned LVL_W = 2;

  typedef enum logic [LVL_W-1:0] {
    RAIL_V1 = 2'b00,
    RAIL_V2 = 2'b01,
    RAIL_V3 = 2'b10,
    RAIL_V4 = 2'b11
  } rail_e;

  // rail choice from the latched display bit and the frame-alternation bit
  function automatic rail_e pick_rail(input logic bit_v, input logic alt_v);
    rail_e r;
    if (alt_v) r = bit_v ? RAIL_V4 : RAIL_V3;
    else       r = bit_v ? RAIL_V1 : RAIL_V2;
    return r;
  endfunction

  // one shift step of a section: new bit enters at index 0
  function automatic logic [63:0] step_shift(input logic [63:0] cur,
                                             input logic ser);
    return {cur[62:0], ser};
  endfunction

endpackage

// File: rtl/seg_cp_edge.sv
module seg_cp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cp_in,
  output logic shift_evt_o
);
  logic cp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cp_q <= 1'b0;
    else        cp_q <= cp_in;
  end

  // high at the previous sample, low now
  assign shift_evt_o = cp_q & ~cp_in;
endmodule

// File: rtl/seg_shift_half.sv
module seg_shift_half #(
  parameter int unsigned DEPTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [DEPTH-1:0] stages_o,
  output logic             tap_o
);
  import seg_pkg::*;

  logic [DEPTH-1:0] stg_q;
  logic [63:0]      widened;
  logic [63:0]      stepped;

  always_comb begin
    widened = '0;
    widened[DEPTH-1:0] = stg_q;
    stepped = step_shift(widened, ser_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        stg_q <= '0;
    else if (shift_en) stg_q <= stepped[DEPTH-1:0];
  end

  assign stages_o = stg_q;
  assign tap_o    = stg_q[DEPTH-1];
endmodule

// File: rtl/seg_hold_latch.sv
module seg_hold_latch #(
  parameter int unsigned WIDTH = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_r;

  always_ff @(posedge clk) begin
    if (!rst_n)       q_r <= '0;
    else if (load_en) q_r <= d_i;
  end

  assign q_o = q_r;
endmodule

// File: rtl/seg_level_map.sv
module seg_level_map #(
  parameter int unsigned NSEG = 40
) (
  input  logic [NSEG-1:0]                 bits_i,
  input  logic                            alt_i,
  output logic [seg_pkg::LVL_W*NSEG-1:0]  lvl_o
);
  import seg_pkg::*;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    rail_e r;
    always_comb r = pick_rail(bits_i[g], alt_i);
    assign lvl_o[LVL_W*g +: LVL_W] = r;
  end
endmodule

// File: rtl/seg_driver_core.sv
module seg_driver_core #(
  parameter int unsigned HALF_W    = 20,
  parameter bit          CHAIN_INT = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cp_in,
  input  logic                      load_in,
  input  logic                      df_in,
  input  logic                      di1_in,
  input  logic                      di21_in,
  output logic                      do20_out,
  output logic                      do40_out,
  output logic [4*HALF_W-1:0]       seg_lvl_out
);
  localparam int unsigned NSEG = 2 * HALF_W;

  logic            shift_evt;
  logic [HALF_W-1:0] lo_bits;
  logic [HALF_W-1:0] hi_bits;
  logic            lo_tap;
  logic            hi_tap;
  logic            hi_feed;
  logic [NSEG-1:0] shift_bits;
  logic [NSEG-1:0] latch_bits;

  seg_cp_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .cp_in      (cp_in),
    .shift_evt_o(shift_evt)
  );

  seg_shift_half #(.DEPTH(HALF_W)) u_lo (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_evt),
    .ser_in  (di1_in),
    .stages_o(lo_bits),
    .tap_o   (lo_tap)
  );

  if (CHAIN_INT) begin : g_joined
    assign hi_feed = lo_tap;
  end else begin : g_split
    assign hi_feed = di21_in;
  end

  seg_shift_half #(.DEPTH(HALF_W)) u_hi (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_evt),
    .ser_in  (hi_feed),
    .stages_o(hi_bits),
    .tap_o   (hi_tap)
  );

  assign shift_bits = {hi_bits, lo_bits};

  seg_hold_latch #(.WIDTH(NSEG)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_en(load_in),
    .d_i    (shift_bits),
    .q_o    (latch_bits)
  );

  seg_level_map #(.NSEG(NSEG)) u_map (
    .bits_i(latch_bits),
    .alt_i (df_in),
    .lvl_o (seg_lvl_out)
  );

  assign do20_out = lo_tap;
  assign do40_out = hi_tap;
endmodule

// File: rtl/seg_driver_core_chk.sv
module seg_driver_core_chk #(
  parameter int unsigned HALF_W    = 20,
  parameter bit          CHAIN_INT = 1'b0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  load_in,
  input logic                  df_in,
  input logic                  di1_in,
  input logic                  di21_in,
  input logic                  shift_evt,
  input logic [2*HALF_W-1:0]   shift_bits,
  input logic [2*HALF_W-1:0]   latch_bits,
  input logic                  do20_out,
  input logic                  do40_out,
  input logic [4*HALF_W-1:0]   seg_lvl_out
);
  localparam int unsigned NSEG = 2 * HALF_W;

  logic [NSEG-1:0] hi_code_bits;
  logic [NSEG-1:0] lo_code_bits;
  always_comb begin
    for (int k = 0; k < NSEG; k++) begin
      hi_code_bits[k] = seg_lvl_out[2*k+1];
      lo_code_bits[k] = seg_lvl_out[2*k];
    end
  end

  p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (shift_bits == '0 && latch_bits == '0));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(shift_bits));

  p_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> shift_bits[0] == $past(di1_in));

  p_mid_tap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> do20_out == $past(shift_bits[HALF_W-2]));

  p_end_tap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> do40_out == $past(shift_bits[NSEG-2]));

  p_second_feed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> shift_bits[HALF_W] ==
      (CHAIN_INT ? $past(shift_bits[HALF_W-1]) : $past(di21_in)));

  p_latch_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_in |=> latch_bits == $past(shift_bits));

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load_in |=> $stable(latch_bits));

  p_alt_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hi_code_bits ^ {NSEG{df_in}}) == 0);

  p_bit_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lo_code_bits ^ ~(latch_bits ^ {NSEG{df_in}})) == 0);
endmodule

bind seg_driver_core seg_driver_core_chk #(
  .HALF_W   (HALF_W),
  .CHAIN_INT(CHAIN_INT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_in    (load_in),
  .df_in      (df_in),
  .di1_in     (di1_in),
  .di21_in    (di21_in),
  .shift_evt  (shift_evt),
  .shift_bits (shift_bits),
  .latch_bits (latch_bits),
  .do20_out   (do20_out),
  .do40_out   (do40_out),
  .seg_lvl_out(seg_lvl_out)
);

// File: tb/seg_driver_core_bench.sv
module seg_driver_core_bench;
  localparam int HW = 20;
  localparam int NS = 2 * HW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cp = 1'b1, load = 1'b0, df = 1'b0, d1 = 1'b0, d21 = 1'b0;
  logic do20_s, do40_s, do20_c, do40_c;
  logic [2*NS-1:0] lvl_s, lvl_c;

  int checks = 0;
  int failures = 0;

  // bench models: index k-1 is stage k
  logic [NS-1:0] ms = '0, mc = '0, ls = '0, lc = '0;

  always #5 clk = ~clk;

  seg_driver_core #(.HALF_W(HW), .CHAIN_INT(1'b0)) u_seg_driver_core (
    .clk(clk), .rst_n(rst_n), .cp_in(cp), .load_in(load), .df_in(df),
    .di1_in(d1), .di21_in(d21), .do20_out(do20_s), .do40_out(do40_s),
    .seg_lvl_out(lvl_s));

  seg_driver_core #(.HALF_W(HW), .CHAIN_INT(1'b1)) u_seg_driver_core_chain (
    .clk(clk), .rst_n(rst_n), .cp_in(cp), .load_in(load), .df_in(df),
    .di1_in(d1), .di21_in(d21), .do20_out(do20_c), .do40_out(do40_c),
    .seg_lvl_out(lvl_c));

  // rail code table as stated in R7
  function automatic logic [1:0] rail(input logic b, input logic f);
    case ({b, f})
      2'b10:   return 2'b00;
      2'b00:   return 2'b01;
      2'b01:   return 2'b10;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [2*NS-1:0] exp_lvl(input logic [NS-1:0] lat,
                                              input logic f);
    logic [2*NS-1:0] v;
    for (int k = 0; k < NS; k++) v[2*k +: 2] = rail(lat[k], f);
    return v;
  endfunction

  task automatic chk(input string req, input logic [2*NS-1:0] act,
                     input logic [2*NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // compare both instances against the models
  task automatic chk_all(input string req);
    chk({req, " lvl split"}, lvl_s, exp_lvl(ls, df));
    chk({req, " lvl chain"}, lvl_c, exp_lvl(lc, df));
    chk({req, " taps split"}, {78'd0, do40_s, do20_s}, {78'd0, ms[NS-1], ms[HW-1]});
    chk({req, " taps chain"}, {78'd0, do40_c, do20_c}, {78'd0, mc[NS-1], mc[HW-1]});
  endtask

  task automatic model_shift(input logic a, input logic b);
    ms = {ms[NS-2:HW], b, ms[HW-2:0], a};
    mc = {mc[NS-2:0], a};
  endtask

  // one strobe: low for lo_cyc clocks, then back high
  task automatic strobe(input logic a, input logic b, input int lo_cyc);
    @(negedge clk);
    d1 = a; d21 = b; cp = 1'b0;
    repeat (lo_cyc) @(negedge clk);
    cp = 1'b1;
    model_shift(a, b);
    if (load) begin ls = ms; lc = mc; end
  endtask

  task automatic pulse_load;
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    ls = ms; lc = mc;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    ms = '0; mc = '0; ls = '0; lc = '0;
  endtask

  // {df, stage21..40 pattern, stage1..20 pattern}
  localparam logic [40:0] VEC [6] = '{
    {1'b0, 20'hFFFFF, 20'h00000},
    {1'b1, 20'h00000, 20'hFFFFF},
    {1'b0, 20'hA5A5A, 20'h5A5A5},
    {1'b1, 20'h12345, 20'hFEDCB},
    {1'b1, 20'h80001, 20'h00010},
    {1'b0, 20'h0F0F0, 20'hC3C3C}
  };

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    chk_all("R8 reset state");

    // R1 R4 R5 R7: walk the vector table (chain instance checked by model, R9)
    for (int i = 0; i < 6; i++) begin
      for (int j = HW - 1; j >= 0; j--) strobe(VEC[i][j], VEC[i][HW + j], 1);
      @(negedge clk); df = VEC[i][40];
      pulse_load();
      chk_all($sformatf("R1 R4 R5 R7 R9 vector %0d", i));
    end

    // R7: df flip with no load changes codes at once
    @(negedge clk); df = ~df; #1;
    chk_all("R7 df flip");

    // R6: shift without load, segment codes stay
    for (int j = 0; j < 7; j++) strobe(j[0], ~j[0], 1);
    @(negedge clk);
    chk_all("R6 hold without load");

    // R2: strobe held low three clocks shifts once only
    strobe(1'b1, 1'b0, 3);
    @(negedge clk);
    chk_all("R2 single shift on long low");
    repeat (4) @(negedge clk);
    chk_all("R2 no shift while idle high");

    // R3: latency of 20 strobes to the mid tap
    do_reset();
    strobe(1'b1, 1'b0, 1);
    for (int j = 0; j < 18; j++) strobe(1'b0, 1'b0, 1);
    @(negedge clk);
    chk({"R3 tap before 20"}, {79'd0, do20_s}, {79'd0, ms[HW-1]});
    strobe(1'b0, 1'b0, 1);
    @(negedge clk);
    chk({"R3 tap at 20"}, {79'd0, do20_s}, 80'd1);

    // R9: joined instance ignores di21, reaches do40 after 40 strobes
    do_reset();
    strobe(1'b1, 1'b1, 1);
    for (int j = 0; j < 39; j++) strobe(1'b0, ~j[0], 1);
    @(negedge clk);
    chk({"R9 chain end tap"}, {79'd0, do40_c}, 80'd1);
    chk_all("R9 chain state");

    // R5: load held high tracks every shift
    @(negedge clk); load = 1'b1; ls = ms; lc = mc;
    @(negedge clk);
    for (int j = 0; j < 5; j++) begin
      strobe(j[1], j[0], 1);
      @(negedge clk);
      chk_all("R5 transparent load");
    end
    @(negedge clk); load = 1'b0;

    // R8: reset in mid operation
    do_reset();
    chk_all("R8 reset after activity");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule